// File: doc/BRIEF.md
# Privilege Mode Access Guard

This block sits beside a small CPU and decides, every cycle, whether the code now executing is privileged. Privilege comes from where the fetch address lies, not from a mode bit. Code inside the supervisor code zone runs privileged. Code inside the user code zone, or anywhere outside the supervisor zone, runs unprivileged. Both zones are held in bound registers that only privileged code can rewrite.

In the unprivileged state the guard suppresses data accesses to the I/O space, the EEPROM space and a programmable RAM window reserved for privileged code. A suppressed write never reaches memory and a suppressed read returns zero. Each such attempt raises a maskable interrupt one cycle later and records the offending address. An unprivileged jump into the supervisor code zone raises a separate non-maskable security interrupt instead. The only legal way into privileged code is a supervisor call, which the guard redirects to one fixed entry vector.

Independently of privilege, a RAM region shared with a coprocessor is closed to the CPU while the coprocessor runs. The guard's own registers appear at a small group of addresses inside the I/O space.

Top module: `priv_guard`

## Requirements
- R1: `sup_mode` is 1 exactly when `pc` lies within [sup_lo, sup_hi] and not within [usr_lo, usr_hi], bounds inclusive. A change to a bound register takes effect from the cycle after the write.
- R2: In the unprivileged state, a read or write to I/O (0x00..0x1F), EEPROM (0x80..0xFF) or the reserved window [rsv_lo, rsv_hi] is blocked in the same cycle. `access_ok`, `mem_rd` and `mem_wr` are 0 and `cpu_rdata` is 0. An allowed read returns `mem_rdata` and raises the matching memory strobe.
- R3: While `cop_active` is 1, any access to the shared region 0x60..0x7F is blocked in both privilege states, with no interrupt raised. While it is 0, that region follows R2 alone.
- R4: A blocked access under R2 makes `irq_viol` 1 in the next cycle, and `fault_addr` then holds `d_addr`. Without a new fault, `fault_addr` keeps its value.
- R5: An unprivileged cycle with `jmp_valid`=1 and `jmp_target` inside the supervisor zone (R1 predicate applied to the target) makes `nmi_sec` 1 in the next cycle, and `fault_addr` then holds the target. Privileged jumps never raise it.
- R6: `svc_req`=1 sets `redirect_valid`=1 and `redirect_pc`=0x10 in the same cycle, and suppresses `nmi_sec` for that cycle's jump.
- R7: Guard registers sit at data addresses 0x18 + k: k=0 sup_lo, 1 sup_hi, 2 usr_lo, 3 usr_hi, 4 rsv_lo, 5 rsv_hi, 6 fault address (read only). A privileged write updates entry k at the next edge, and a privileged read returns it in the same cycle. The memory strobes stay 0 for these addresses, and an unprivileged write leaves them unchanged (blocked per R2).
- R8: After reset: sup 0x00..0x3F, usr 0x40..0xFF, rsv 0x20..0x2F, fault address 0x00, `irq_viol` and `nmi_sec` 0.
- R9: When one cycle triggers both R4 and R5, only `nmi_sec` is raised and `fault_addr` takes the jump target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc | input | 8 | Address of the instruction executing |
| jmp_valid | input | 1 | A jump or taken branch this cycle |
| jmp_target | input | 8 | Destination of that jump |
| svc_req | input | 1 | Supervisor-call instruction executing |
| d_addr | input | 8 | Data access address |
| d_rd | input | 1 | Data read strobe from CPU |
| d_wr | input | 1 | Data write strobe from CPU |
| d_wdata | input | 8 | Write data (used for guard registers) |
| mem_rdata | input | 8 | Read data from memory |
| cop_active | input | 1 | Coprocessor running |
| access_ok | output | 1 | Current access is allowed |
| mem_rd | output | 1 | Read strobe passed to memory |
| mem_wr | output | 1 | Write strobe passed to memory |
| cpu_rdata | output | 8 | Read data returned to CPU |
| sup_mode | output | 1 | Privileged state |
| irq_viol | output | 1 | Maskable access-violation interrupt |
| nmi_sec | output | 1 | Non-maskable security interrupt |
| fault_addr | output | 8 | Last offending address |
| redirect_valid | output | 1 | Supervisor-call redirect |
| redirect_pc | output | 8 | Supervisor-call entry vector |

## Verification
The access decision, the memory strobes, the returned read data, the privilege flag and the call redirect all depend only on the current inputs and register state. The bench therefore samples them one time unit after it drives inputs at the falling edge, inside the same cycle. The two interrupts, the fault address and bound-register writes take effect one rising edge later, and are checked at the following falling edge, before the next stimulus is applied. A bench model of the bound registers and fault address drives every expected value through sweeps over all 256 data addresses and jump targets in both privilege states, with the coprocessor idle and running.

// File: rtl/priv_guard_pkg.sv
package priv_guard_pkg;
  localparam int NUM_BOUND = 6;
  localparam int NUM_GREG  = 7;
  localparam int GIDX_W    = 3;

  typedef enum logic [GIDX_W-1:0] {
    G_SUP_LO = 3'd0,
    G_SUP_HI = 3'd1,
    G_USR_LO = 3'd2,
    G_USR_HI = 3'd3,
    G_RSV_LO = 3'd4,
    G_RSV_HI = 3'd5,
    G_FAULT  = 3'd6
  } greg_e;
endpackage

// File: rtl/pg_zone_regs.sv
module pg_zone_regs
  import priv_guard_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] RST_SUP_LO = 8'h00,
  parameter logic [AW-1:0] RST_SUP_HI = 8'h3F,
  parameter logic [AW-1:0] RST_USR_LO = 8'h40,
  parameter logic [AW-1:0] RST_USR_HI = 8'hFF,
  parameter logic [AW-1:0] RST_RSV_LO = 8'h20,
  parameter logic [AW-1:0] RST_RSV_HI = 8'h2F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [GIDX_W-1:0] cfg_idx,
  input  logic [AW-1:0]     cfg_wdata,
  input  logic              fault_we,
  input  logic [AW-1:0]     fault_val,
  input  logic [GIDX_W-1:0] rd_idx,
  output logic [AW-1:0]     sup_lo,
  output logic [AW-1:0]     sup_hi,
  output logic [AW-1:0]     usr_lo,
  output logic [AW-1:0]     usr_hi,
  output logic [AW-1:0]     rsv_lo,
  output logic [AW-1:0]     rsv_hi,
  output logic [AW-1:0]     fault_addr,
  output logic [AW-1:0]     rd_val
);
  localparam logic [AW-1:0] RST_VAL [NUM_BOUND] =
    '{RST_SUP_LO, RST_SUP_HI, RST_USR_LO, RST_USR_HI, RST_RSV_LO, RST_RSV_HI};

  logic [AW-1:0]        bound_q [NUM_BOUND];
  logic [NUM_BOUND-1:0] bound_en;
  logic [AW-1:0]        fault_q;

  // one write enable per bound entry
  for (genvar g = 0; g < NUM_BOUND; g++) begin : g_en
    assign bound_en[g] = cfg_we && (cfg_idx == GIDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BOUND; i++) bound_q[i] <= RST_VAL[i];
    end else begin
      for (int i = 0; i < NUM_BOUND; i++)
        if (bound_en[i]) bound_q[i] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fault_q <= '0;
    else if (fault_we) fault_q <= fault_val;
  end

  assign sup_lo     = bound_q[G_SUP_LO];
  assign sup_hi     = bound_q[G_SUP_HI];
  assign usr_lo     = bound_q[G_USR_LO];
  assign usr_hi     = bound_q[G_USR_HI];
  assign rsv_lo     = bound_q[G_RSV_LO];
  assign rsv_hi     = bound_q[G_RSV_HI];
  assign fault_addr = fault_q;

  always_comb begin
    case (greg_e'(rd_idx))
      G_SUP_LO: rd_val = bound_q[G_SUP_LO];
      G_SUP_HI: rd_val = bound_q[G_SUP_HI];
      G_USR_LO: rd_val = bound_q[G_USR_LO];
      G_USR_HI: rd_val = bound_q[G_USR_HI];
      G_RSV_LO: rd_val = bound_q[G_RSV_LO];
      G_RSV_HI: rd_val = bound_q[G_RSV_HI];
      default:  rd_val = fault_q;
    endcase
  end

  // R7: bounds move only on an enabled write
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(sup_lo) && $stable(sup_hi) && $stable(usr_lo) &&
                 $stable(usr_hi) && $stable(rsv_lo) && $stable(rsv_hi)));

  // R4: fault address is held when no fault is captured
  p_fault_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_we |=> $stable(fault_addr));
endmodule

// File: rtl/pg_classify.sv
module pg_classify
  import priv_guard_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] IO_LO     = 8'h00,
  parameter logic [AW-1:0] IO_HI     = 8'h1F,
  parameter logic [AW-1:0] SH_LO     = 8'h60,
  parameter logic [AW-1:0] SH_HI     = 8'h7F,
  parameter logic [AW-1:0] EE_LO     = 8'h80,
  parameter logic [AW-1:0] EE_HI     = 8'hFF,
  parameter logic [AW-1:0] GREG_BASE = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     pc,
  input  logic              jmp_valid,
  input  logic [AW-1:0]     jmp_target,
  input  logic              svc_req,
  input  logic [AW-1:0]     d_addr,
  input  logic              d_rd,
  input  logic              d_wr,
  input  logic              cop_active,
  input  logic [AW-1:0]     sup_lo,
  input  logic [AW-1:0]     sup_hi,
  input  logic [AW-1:0]     usr_lo,
  input  logic [AW-1:0]     usr_hi,
  input  logic [AW-1:0]     rsv_lo,
  input  logic [AW-1:0]     rsv_hi,
  output logic              sup_mode,
  output logic              viol,
  output logic              nmi_cause,
  output logic              access_ok,
  output logic              greg_hit,
  output logic [GIDX_W-1:0] greg_idx
);
  localparam logic [AW-1:0] GREG_LAST = GREG_BASE + AW'(NUM_GREG - 1);

  function automatic logic in_rng(input logic [AW-1:0] a, lo, hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic priv_at(input logic [AW-1:0] a,
                                   input logic [AW-1:0] slo, shi, ulo, uhi);
    return in_rng(a, slo, shi) && !in_rng(a, ulo, uhi);
  endfunction

  logic req, prot_hit, share_lock, tgt_priv;

  always_comb begin
    sup_mode   = priv_at(pc, sup_lo, sup_hi, usr_lo, usr_hi);
    tgt_priv   = priv_at(jmp_target, sup_lo, sup_hi, usr_lo, usr_hi);
    req        = d_rd | d_wr;
    prot_hit   = in_rng(d_addr, IO_LO, IO_HI) | in_rng(d_addr, EE_LO, EE_HI) |
                 in_rng(d_addr, rsv_lo, rsv_hi);
    viol       = req & ~sup_mode & prot_hit;
    share_lock = req & cop_active & in_rng(d_addr, SH_LO, SH_HI);
    access_ok  = req & ~viol & ~share_lock;
    nmi_cause  = jmp_valid & ~svc_req & ~sup_mode & tgt_priv;
    greg_hit   = in_rng(d_addr, GREG_BASE, GREG_LAST);
    greg_idx   = GIDX_W'(d_addr - GREG_BASE);
  end

  // R3: shared region closed while the coprocessor runs
  p_share_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_active && (d_rd || d_wr) && d_addr >= SH_LO && d_addr <= SH_HI) |-> !access_ok);

  // R2: unprivileged I/O access never allowed
  p_user_io_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_mode && (d_rd || d_wr) && d_addr >= IO_LO && d_addr <= IO_HI) |-> !access_ok);
endmodule

// File: rtl/pg_irq.sv
module pg_irq #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          viol,
  input  logic          nmi_cause,
  input  logic [AW-1:0] d_addr,
  input  logic [AW-1:0] jmp_target,
  output logic          irq_viol,
  output logic          nmi_sec,
  output logic          fault_we,
  output logic [AW-1:0] fault_val
);
  logic irq_d, nmi_d, irq_q, nmi_q;

  always_comb begin
    irq_d     = viol & ~nmi_cause;
    nmi_d     = nmi_cause;
    fault_we  = viol | nmi_cause;
    fault_val = nmi_cause ? jmp_target : d_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      nmi_q <= nmi_d;
    end
  end

  assign irq_viol = irq_q;
  assign nmi_sec  = nmi_q;

  // R4: a lone violation is signalled next cycle
  p_viol_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !nmi_cause) |=> irq_viol);

  // R9: non-maskable class wins when both fire
  p_nmi_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_cause |=> (nmi_sec && !irq_viol));

  // R5: no security interrupt without a cause
  p_nmi_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_cause |=> !nmi_sec);
endmodule

// File: rtl/priv_guard.sv
module priv_guard
  import priv_guard_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] IO_LO      = 8'h00,
  parameter logic [AW-1:0] IO_HI      = 8'h1F,
  parameter logic [AW-1:0] SH_LO      = 8'h60,
  parameter logic [AW-1:0] SH_HI      = 8'h7F,
  parameter logic [AW-1:0] EE_LO      = 8'h80,
  parameter logic [AW-1:0] EE_HI      = 8'hFF,
  parameter logic [AW-1:0] GREG_BASE  = 8'h18,
  parameter logic [AW-1:0] SVC_VEC    = 8'h10,
  parameter logic [AW-1:0] RST_SUP_LO = 8'h00,
  parameter logic [AW-1:0] RST_SUP_HI = 8'h3F,
  parameter logic [AW-1:0] RST_USR_LO = 8'h40,
  parameter logic [AW-1:0] RST_USR_HI = 8'hFF,
  parameter logic [AW-1:0] RST_RSV_LO = 8'h20,
  parameter logic [AW-1:0] RST_RSV_HI = 8'h2F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc,
  input  logic          jmp_valid,
  input  logic [AW-1:0] jmp_target,
  input  logic          svc_req,
  input  logic [AW-1:0] d_addr,
  input  logic          d_rd,
  input  logic          d_wr,
  input  logic [AW-1:0] d_wdata,
  input  logic [AW-1:0] mem_rdata,
  input  logic          cop_active,
  output logic          access_ok,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] cpu_rdata,
  output logic          sup_mode,
  output logic          irq_viol,
  output logic          nmi_sec,
  output logic [AW-1:0] fault_addr,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  logic [AW-1:0]     sup_lo, sup_hi, usr_lo, usr_hi, rsv_lo, rsv_hi;
  logic [AW-1:0]     greg_val, fault_val;
  logic [GIDX_W-1:0] greg_idx;
  logic              viol, nmi_cause, greg_hit, cfg_we, fault_we;

  pg_classify #(
    .AW(AW), .IO_LO(IO_LO), .IO_HI(IO_HI), .SH_LO(SH_LO), .SH_HI(SH_HI),
    .EE_LO(EE_LO), .EE_HI(EE_HI), .GREG_BASE(GREG_BASE)
  ) u_cls (
    .clk(clk), .rst_n(rst_n_s), .pc(pc), .jmp_valid(jmp_valid),
    .jmp_target(jmp_target), .svc_req(svc_req), .d_addr(d_addr),
    .d_rd(d_rd), .d_wr(d_wr), .cop_active(cop_active),
    .sup_lo(sup_lo), .sup_hi(sup_hi), .usr_lo(usr_lo), .usr_hi(usr_hi),
    .rsv_lo(rsv_lo), .rsv_hi(rsv_hi), .sup_mode(sup_mode), .viol(viol),
    .nmi_cause(nmi_cause), .access_ok(access_ok), .greg_hit(greg_hit),
    .greg_idx(greg_idx)
  );

  pg_irq #(.AW(AW)) u_irq (
    .clk(clk), .rst_n(rst_n_s), .viol(viol), .nmi_cause(nmi_cause),
    .d_addr(d_addr), .jmp_target(jmp_target), .irq_viol(irq_viol),
    .nmi_sec(nmi_sec), .fault_we(fault_we), .fault_val(fault_val)
  );

  pg_zone_regs #(
    .AW(AW), .RST_SUP_LO(RST_SUP_LO), .RST_SUP_HI(RST_SUP_HI),
    .RST_USR_LO(RST_USR_LO), .RST_USR_HI(RST_USR_HI),
    .RST_RSV_LO(RST_RSV_LO), .RST_RSV_HI(RST_RSV_HI)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_s), .cfg_we(cfg_we), .cfg_idx(greg_idx),
    .cfg_wdata(d_wdata), .fault_we(fault_we), .fault_val(fault_val),
    .rd_idx(greg_idx), .sup_lo(sup_lo), .sup_hi(sup_hi), .usr_lo(usr_lo),
    .usr_hi(usr_hi), .rsv_lo(rsv_lo), .rsv_hi(rsv_hi),
    .fault_addr(fault_addr), .rd_val(greg_val)
  );

  always_comb begin
    cfg_we    = d_wr & access_ok & greg_hit & (greg_idx < GIDX_W'(NUM_BOUND));
    mem_rd    = d_rd & access_ok & ~greg_hit;
    mem_wr    = d_wr & access_ok & ~greg_hit;
    cpu_rdata = '0;
    if (d_rd && access_ok) cpu_rdata = greg_hit ? greg_val : mem_rdata;
    redirect_valid = svc_req;
    redirect_pc    = SVC_VEC;
  end

  // R6: a supervisor call never raises the security interrupt
  p_svc_no_nmi_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    svc_req |=> !nmi_sec);

  // R7: guard register accesses stay off the memory bus
  p_greg_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    greg_hit |-> (!mem_rd && !mem_wr));
endmodule

// File: tb/priv_guard_test.sv
module priv_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pc, jmp_target, d_addr, d_wdata, mem_rdata;
  logic       jmp_valid, svc_req, d_rd, d_wr, cop_active;
  logic       access_ok, mem_rd, mem_wr, sup_mode, irq_viol, nmi_sec, redirect_valid;
  logic [7:0] cpu_rdata, fault_addr, redirect_pc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] mb [6];
  logic [7:0] mfault;

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_guard uut (
    .clk(clk), .rst_n(rst_n), .pc(pc), .jmp_valid(jmp_valid),
    .jmp_target(jmp_target), .svc_req(svc_req), .d_addr(d_addr),
    .d_rd(d_rd), .d_wr(d_wr), .d_wdata(d_wdata), .mem_rdata(mem_rdata),
    .cop_active(cop_active), .access_ok(access_ok), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .cpu_rdata(cpu_rdata), .sup_mode(sup_mode),
    .irq_viol(irq_viol), .nmi_sec(nmi_sec), .fault_addr(fault_addr),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic in_rng(input logic [7:0] a, lo, hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic is_priv(input logic [7:0] a);
    return in_rng(a, mb[0], mb[1]) && !in_rng(a, mb[2], mb[3]);
  endfunction

  // one cycle: drive at falling edge, check same-cycle outputs, then next-cycle outputs
  task automatic step(input logic [7:0] p, input logic jv, input logic [7:0] jt,
                      input logic sv, input logic [7:0] a, input logic rd, wr,
                      input logic [7:0] wd, input logic cp, input string rtag);
    logic       priv, req, prot, shl, ok, greg, nmi_c;
    logic [7:0] gval, exp_rd, nfault;
    int         gi;
    pc = p; jmp_valid = jv; jmp_target = jt; svc_req = sv; d_addr = a;
    d_rd = rd; d_wr = wr; d_wdata = wd; cop_active = cp; mem_rdata = a ^ 8'hA5;
    priv  = is_priv(p);
    req   = rd | wr;
    prot  = !priv && req && (in_rng(a, 8'h00, 8'h1F) || in_rng(a, 8'h80, 8'hFF) ||
                             in_rng(a, mb[4], mb[5]));
    shl   = cp && req && in_rng(a, 8'h60, 8'h7F);
    ok    = req && !prot && !shl;
    greg  = in_rng(a, 8'h18, 8'h1E);
    gi    = int'(a) - 24;
    gval  = (greg && gi < 6) ? mb[gi] : mfault;
    exp_rd = (rd && ok) ? (greg ? gval : (a ^ 8'hA5)) : 8'h00;
    nmi_c = !priv && jv && !sv && is_priv(jt);
    nfault = nmi_c ? jt : (prot ? a : mfault);
    #1;
    chk("R1", "sup_mode", sup_mode, priv);
    chk(shl && !prot ? "R3" : "R2", "access_ok", access_ok, ok);
    chk(greg ? "R7" : "R2", "mem_rd", mem_rd, rd && ok && !greg);
    chk(greg ? "R7" : "R2", "mem_wr", mem_wr, wr && ok && !greg);
    chk(rtag, "cpu_rdata", cpu_rdata, exp_rd);
    chk("R6", "redirect_valid", redirect_valid, sv);
    chk("R6", "redirect_pc", redirect_pc, 8'h10);
    if (wr && ok && greg && gi < 6) mb[gi] = wd;
    mfault = nfault;
    @(negedge clk);
    chk(nmi_c && prot ? "R9" : "R4", "irq_viol", irq_viol, prot && !nmi_c);
    chk(sv ? "R6" : "R5", "nmi_sec", nmi_sec, nmi_c);
    chk(nmi_c ? "R5" : "R4", "fault_addr", fault_addr, mfault);
  endtask

  task automatic idle(input logic [7:0] p);
    step(p, 1'b0, 8'h00, 1'b0, 8'h40, 1'b0, 1'b0, 8'h00, 1'b0, "R2");
  endtask

  initial begin
    mb[0] = 8'h00; mb[1] = 8'h3F; mb[2] = 8'h40;
    mb[3] = 8'hFF; mb[4] = 8'h20; mb[5] = 8'h2F;
    mfault = 8'h00;
    rst_n = 1'b0; pc = 8'h00; jmp_valid = 1'b0; jmp_target = 8'h00; svc_req = 1'b0;
    d_addr = 8'h00; d_rd = 1'b0; d_wr = 1'b0; d_wdata = 8'h00; mem_rdata = 8'h00;
    cop_active = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: reset state at the ports, then each guard register read back
    chk("R8", "irq_viol", irq_viol, 1'b0);
    chk("R8", "nmi_sec", nmi_sec, 1'b0);
    chk("R8", "fault_addr", fault_addr, 8'h00);
    for (int k = 0; k < 7; k++)
      step(8'h05, 1'b0, 8'h00, 1'b0, 8'(24 + k), 1'b1, 1'b0, 8'h00, 1'b0, "R8");

    // R1: privilege over every fetch address, default zones
    for (int p = 0; p < 256; p++) idle(8'(p));

    // R2 R3 R4: every data address, both privilege states, coprocessor idle and running
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 256; a++)
          for (int w = 0; w < 2; w++) begin
            if (m == 0 && a >= 24 && a <= 30) continue;
            step(m == 0 ? 8'h05 : 8'h80, 1'b0, 8'h00, 1'b0, 8'(a),
                 w == 0, w == 1, 8'(a), c[0], "R2");
          end

    // R5: every jump target from an unprivileged and a privileged fetch address
    for (int t = 0; t < 256; t++)
      step(8'h80, 1'b1, 8'(t), 1'b0, 8'h40, 1'b0, 1'b0, 8'h00, 1'b0, "R5");
    for (int t = 0; t < 256; t++)
      step(8'h05, 1'b1, 8'(t), 1'b0, 8'h40, 1'b0, 1'b0, 8'h00, 1'b0, "R5");

    // R6: supervisor call from user code, jump aimed at the vector, no NMI
    step(8'h80, 1'b1, 8'h10, 1'b1, 8'h40, 1'b0, 1'b0, 8'h00, 1'b0, "R6");
    step(8'h05, 1'b0, 8'h00, 1'b1, 8'h40, 1'b0, 1'b0, 8'h00, 1'b0, "R6");

    // R9: forbidden write and forbidden jump in one cycle
    step(8'h80, 1'b1, 8'h05, 1'b0, 8'h00, 1'b0, 1'b1, 8'h77, 1'b0, "R9");
    step(8'h80, 1'b1, 8'h33, 1'b0, 8'h85, 1'b1, 1'b0, 8'h00, 1'b0, "R9");

    // R7: move the reserved window, read it back, probe old and new windows
    step(8'h05, 1'b0, 8'h00, 1'b0, 8'h1C, 1'b0, 1'b1, 8'h48, 1'b0, "R7");
    step(8'h05, 1'b0, 8'h00, 1'b0, 8'h1D, 1'b0, 1'b1, 8'h4F, 1'b0, "R7");
    step(8'h05, 1'b0, 8'h00, 1'b0, 8'h1C, 1'b1, 1'b0, 8'h00, 1'b0, "R7");
    step(8'h05, 1'b0, 8'h00, 1'b0, 8'h1D, 1'b1, 1'b0, 8'h00, 1'b0, "R7");
    for (int a = 8'h20; a < 8'h60; a++)
      step(8'h80, 1'b0, 8'h00, 1'b0, 8'(a), 1'b1, 1'b0, 8'h00, 1'b0, "R7");
    // R7: user write to sup_lo blocked, value unchanged when read privileged
    step(8'h80, 1'b0, 8'h00, 1'b0, 8'h18, 1'b0, 1'b1, 8'hAA, 1'b0, "R7");
    step(8'h05, 1'b0, 8'h00, 1'b0, 8'h18, 1'b1, 1'b0, 8'h00, 1'b0, "R7");
    // R7: fault address entry is read only
    step(8'h05, 1'b0, 8'h00, 1'b0, 8'h1E, 1'b0, 1'b1, 8'hCC, 1'b0, "R7");
    step(8'h05, 1'b0, 8'h00, 1'b0, 8'h1E, 1'b1, 1'b0, 8'h00, 1'b0, "R7");

    // R1: overlapping user zone 0x20..0x2F carved out of the supervisor zone
    step(8'h05, 1'b0, 8'h00, 1'b0, 8'h1A, 1'b0, 1'b1, 8'h20, 1'b0, "R7");
    step(8'h05, 1'b0, 8'h00, 1'b0, 8'h1B, 1'b0, 1'b1, 8'h2F, 1'b0, "R7");
    for (int p = 0; p < 256; p++) idle(8'(p));
    // R5: jump into the carved-out user zone raises nothing, into the rest it does
    step(8'hC0, 1'b1, 8'h28, 1'b0, 8'h40, 1'b0, 1'b0, 8'h00, 1'b0, "R5");
    step(8'hC0, 1'b1, 8'h30, 1'b0, 8'h40, 1'b0, 1'b0, 8'h00, 1'b0, "R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule